// File: doc/BRIEF.md
# Predicated Lane-Split Writeback Masker

This block sits between a lane-partitioned adder and a register-file write port with byte-level write enables. A 64-bit word is split into one, two, four or eight lanes, depending on an element-size code. Each lane has its own predicate bit. The unit adds the two operands lane by lane, with no carry crossing a lane boundary. It then produces the write data and eight byte enables for the register file.

Two policies handle lanes whose predicate bit is clear. In merge mode the unit withholds the enables of those bytes, so the register keeps its old contents and no read-modify-write is needed. In zeroing mode those bytes are written as zero, so every byte enable is set. An invert bit complements the predicate before use. An unpredicated flag forces the predicate to all ones. All outputs are registered, so results appear one cycle after a valid input.

Top module: `pred_wb_mask`

## Requirements
- R1: The element-size code `esize` selects the lanes: 0 gives one 64-bit lane, 1 gives two 32-bit lanes, 2 gives four 16-bit lanes and 3 gives eight 8-bit lanes. Lane i occupies bits [(i+1)*W-1 : i*W], with lane 0 at the least significant end.
- R2: The sum in each lane is taken modulo 2^W for that lane's width W. No carry passes into the next lane.
- R3: Predicate bit i governs lane i. Bits at index i >= lane count are ignored; for example, in 64-bit mode only bit 0 counts.
- R4: In merge mode (`zero_mode`=0) each byte enable is 1 exactly when the lane containing that byte is active. The write data of an active lane is its lane sum.
- R5: In zeroing mode (`zero_mode`=1) all eight byte enables are 1. An inactive lane's data bits are zero, and an active lane's data bits are its sum.
- R6: When `pred_inv`=1, the predicate is complemented before lane selection.
- R7: When `unpred`=1, every lane is active, regardless of `pred` and `pred_inv`.
- R8: `out_valid` is `in_valid` delayed by one cycle. Data and enables are registered on a valid input and are due in that same following cycle.
- R9: While `out_valid` is 0, `byte_en` is all zeros. After reset, `out_valid`=0, `byte_en`=0 and `wr_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| esize | input | 2 | Element-size code (0:64, 1:32, 2:16, 3:8 bits) |
| zero_mode | input | 1 | 1 = zero inactive lanes, 0 = merge (withhold write) |
| pred_inv | input | 1 | Complement the predicate |
| unpred | input | 1 | Treat all lanes as active |
| pred | input | 8 | Raw per-lane predicate |
| out_valid | output | 1 | Write strobe, one cycle after `in_valid` |
| wr_data | output | 64 | Register-file write data |
| byte_en | output | 8 | Per-byte write enables |

## Verification
Every result of this unit is due exactly one clock after the input that caused it: the data, the byte enables and the valid strobe all pass through a single register stage. The bench drives each input on the falling edge and waits for the next rising edge. It then samples on the following falling edge and compares all three outputs with a model computed from the requirements. Between operations the bench drops `in_valid` and checks one cycle later that the valid strobe and the enables have returned to zero.

// File: rtl/pred_wb_pkg.sv
package pred_wb_pkg;
    localparam int DATA_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = DATA_W / BYTE_W;
    localparam int ESIZE_W = 2;

    typedef enum logic [ESIZE_W-1:0] {
        ES_64 = 2'd0,
        ES_32 = 2'd1,
        ES_16 = 2'd2,
        ES_8  = 2'd3
    } esize_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [NBYTES-1:0] ben;
    } wb_t;

    // number of bytes per lane for a size code
    function automatic int unsigned lane_bytes(esize_e es);
        case (es)
            ES_64:   return 8;
            ES_32:   return 4;
            ES_16:   return 2;
            default: return 1;
        endcase
    endfunction

    // bit k of result: 1 when byte k is the top byte of its lane
    function automatic logic [NBYTES-1:0] lane_top_bytes(esize_e es);
        logic [NBYTES-1:0] m;
        int unsigned lb;
        lb = lane_bytes(es);
        for (int k = 0; k < NBYTES; k++)
            m[k] = ((k + 1) % lb) == 0;
        return m;
    endfunction
endpackage

// File: rtl/pred_lane_adder.sv
module pred_lane_adder
    import pred_wb_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  esize_e            es,
    output logic [DATA_W-1:0] sum
);
    logic [NBYTES-1:0] cut;
    logic [NBYTES:0]   cy;

    assign cut = lane_top_bytes(es);
    assign cy[0] = 1'b0;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        logic [BYTE_W:0] part;
        assign part = {1'b0, a[k*BYTE_W +: BYTE_W]} + {1'b0, b[k*BYTE_W +: BYTE_W]}
                    + {{BYTE_W{1'b0}}, cy[k]};
        assign sum[k*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
        // carry is cut at each lane's top byte
        assign cy[k+1] = part[BYTE_W] & ~cut[k];
    end
endmodule

// File: rtl/pred_byte_expand.sv
module pred_byte_expand
    import pred_wb_pkg::*;
(
    input  logic [NBYTES-1:0] pred,
    input  logic              inv,
    input  logic              unpred,
    input  esize_e            es,
    output logic [NBYTES-1:0] byte_act
);
    logic [NBYTES-1:0] eff;
    assign eff = unpred ? {NBYTES{1'b1}} : (inv ? ~pred : pred);

    always_comb begin
        for (int k = 0; k < NBYTES; k++) begin
            case (es)
                ES_64:   byte_act[k] = eff[0];
                ES_32:   byte_act[k] = eff[k/4];
                ES_16:   byte_act[k] = eff[k/2];
                default: byte_act[k] = eff[k];
            endcase
        end
    end

    // R7: unpredicated means every byte active
    always_comb begin
        assert_unpred_all_R7: assert (!unpred || byte_act == {NBYTES{1'b1}});
    end
endmodule

// File: rtl/pred_wb_mask.sv
module pred_wb_mask
    import pred_wb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    input  logic [1:0]        esize,
    input  logic              zero_mode,
    input  logic              pred_inv,
    input  logic              unpred,
    input  logic [7:0]        pred,
    output logic              out_valid,
    output logic [63:0]       wr_data,
    output logic [7:0]        byte_en
);
    esize_e            es;
    logic [DATA_W-1:0] sum;
    logic [NBYTES-1:0] act;
    logic [DATA_W-1:0] bitmask;
    wb_t               nxt, q;

    assign es = esize_e'(esize);

    pred_lane_adder u_add (.a(opa), .b(opb), .es(es), .sum(sum));

    pred_byte_expand u_exp (.pred(pred), .inv(pred_inv), .unpred(unpred),
                            .es(es), .byte_act(act));

    for (genvar k = 0; k < NBYTES; k++) begin : g_mask
        assign bitmask[k*BYTE_W +: BYTE_W] = {BYTE_W{act[k]}};
    end

    always_comb begin
        nxt.valid = in_valid;
        nxt.data  = sum & bitmask;
        nxt.ben   = zero_mode ? {NBYTES{1'b1}} : act;
        if (!in_valid) begin
            nxt.data = '0;
            nxt.ben  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign out_valid = q.valid;
    assign wr_data   = q.data;
    assign byte_en   = q.ben;

    assert_valid_lat_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_idle_ben_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> byte_en == '0);
    assert_zero_allen_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zero_mode) |=> byte_en == '1);
    assert_unpred_full_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && unpred) |=> byte_en == '1);
endmodule

// File: tb/pred_wb_mask_bench.sv
module pred_wb_mask_bench;
    logic clk = 0, rst = 1;
    logic in_valid = 0, zero_mode = 0, pred_inv = 0, unpred = 0;
    logic [63:0] opa = 0, opb = 0;
    logic [1:0] esize = 0;
    logic [7:0] pred = 0;
    logic out_valid;
    logic [63:0] wr_data;
    logic [7:0] byte_en;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pred_wb_mask u_pred_wb_mask (.clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa),
        .opb(opb), .esize(esize), .zero_mode(zero_mode), .pred_inv(pred_inv),
        .unpred(unpred), .pred(pred), .out_valid(out_valid), .wr_data(wr_data),
        .byte_en(byte_en));

    function automatic int lb(logic [1:0] e);
        return 8 >> e;
    endfunction

    function automatic logic [7:0] model_act(logic [1:0] e, logic [7:0] p, logic iv, logic up);
        logic [7:0] r, ef;
        ef = up ? 8'hFF : (iv ? ~p : p);
        for (int k = 0; k < 8; k++) r[k] = ef[k / lb(e)];
        return r;
    endfunction

    function automatic logic [63:0] model_sum(logic [1:0] e, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        int w;
        w = lb(e) * 8;
        for (int l = 0; l < 64 / w; l++) begin
            logic [63:0] m, s;
            m = (w == 64) ? '1 : ((64'd1 << w) - 1);
            s = ((a >> (l*w)) & m) + ((b >> (l*w)) & m);
            r = (r & ~(m << (l*w))) | ((s & m) << (l*w));
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [1:0] e, logic [63:0] a, logic [63:0] b,
                       logic z, logic iv, logic up, logic [7:0] p);
        logic [7:0] act;
        logic [63:0] dm;
        @(negedge clk);
        in_valid = 1; esize = e; opa = a; opb = b;
        zero_mode = z; pred_inv = iv; unpred = up; pred = p;
        act = model_act(e, p, iv, up);
        for (int k = 0; k < 8; k++) dm[k*8 +: 8] = {8{act[k]}};
        @(negedge clk);
        in_valid = 0;
        chk({req, " valid"}, {63'b0, out_valid}, 64'd1);
        chk({req, " data"}, wr_data, model_sum(e, a, b) & dm);
        chk({req, " ben"}, {56'b0, byte_en}, {56'b0, z ? 8'hFF : act});
        @(negedge clk);
        chk("R9 idle", {55'b0, out_valid, byte_en}, 64'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R9 reset", {out_valid, byte_en, wr_data[54:0]}, 64'd0);
        // R2: carry isolation across every width
        run("R2 R1 8b", 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 1, 8'h00);
        run("R2 R1 16b", 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 0, 0, 1, 8'h00);
        run("R2 R1 32b", 2'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 0, 0, 8'h03);
        run("R2 64b", 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0, 0, 8'h01);
        // R3: ignored upper predicate bits in 64-bit mode
        run("R3 64b ignore", 2'd0, 64'h1234, 64'h1, 0, 0, 0, 8'hFE);
        run("R3 32b ignore", 2'd1, 64'h5, 64'h7, 0, 0, 0, 8'hFD);
        // R4 merge, R5 zeroing
        run("R4 merge", 2'd2, 64'h1111_2222_3333_4444, 64'h1, 0, 0, 0, 8'h05);
        run("R5 zero", 2'd3, 64'h1111_2222_3333_4444, 64'h1, 1, 0, 0, 8'hA5);
        // R6 inversion, R7 unpred
        run("R6 invert", 2'd3, 64'hAAAA, 64'h5555, 0, 1, 0, 8'h0F);
        run("R7 unpred", 2'd3, 64'h77, 64'h88, 1, 1, 1, 8'h00);
        // R8 random mix
        for (int i = 0; i < 200; i++)
            run("R8 rand", 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                1'($urandom), 1'($urandom), 1'(($urandom % 5) == 0), 8'($urandom));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule